// File: doc/BRIEF.md
# Dual-Channel Shared-Coefficient FIR Engine

This block filters a stereo pair of audio streams with one multiply-accumulate datapath and one coefficient store shared by both channels. Each channel owns a circular history of `TAPS` samples and a saved position in it. A `start` pulse delivers one new left and one new right sample. The engine then runs a full pass on the left channel and a full pass on the right channel. It puts the two rounded, saturated 16-bit results in output registers and raises `done`.

Coefficients are loaded through a single-cycle write port. A controller state machine sequences the work through five named states:
- `ST_IDLE` waits. An accepted start moves it to `ST_LOAD`.
- `ST_LOAD` restores the channel pointer, writes the new sample at that position, clears the accumulator and moves to `ST_MAC`.
- `ST_MAC` runs `TAPS-1` multiply-accumulates. When the tap index reaches `TAPS-2` it moves to `ST_LAST`.
- `ST_LAST` performs the final multiply-accumulate and always moves to `ST_STORE`.
- `ST_STORE` rounds and saturates the result into the channel's output and saves the pointer. It then goes back to `ST_LOAD` for the right channel, or to `ST_IDLE` with `done` set after the right channel.

Top module: `stereo_fir_engine`

## Requirements
- R1: After reset, both outputs are zero and `busy`, `done` and `overrun` are low. All coefficients and both histories are zero, so a pass run before any coefficient write yields zero on both outputs.
- R2: When `coef_we` is high on a rising edge, `coef_wdata` is stored as coefficient number `coef_addr`.
- R3: Each start accepted in `ST_IDLE` captures `left_in` and `right_in`. The captured sample is written into its channel's history before that channel is filtered. The two histories and their saved pointers never affect each other.
- R4: With x[n] the newest sample of a channel, the pass computes sum over k = 0..TAPS-1 of c[k] * x[n-(TAPS-1-k)]. Coefficient 0 therefore meets the oldest held sample and coefficient TAPS-1 meets the newest. Samples older than reset count as zero.
- R5: Each product is a signed 16x16 fractional product, a*b*2, summed into a 40-bit accumulator. The result is floor((acc + 2^15) / 2^16).
- R6: A result above 32767 gives 0x7FFF and a result below -32768 gives 0x8000.
- R7: The left pass runs first, then the right. `busy` is high from the edge after an accepted start until `done` rises, and `done` rises exactly 2*TAPS+4 rising edges after the accepting edge.
- R8: `done` and both outputs hold their values until the next accepted start. `done` falls on the edge that accepts a start.
- R9: A start seen while `busy` is ignored: neither its samples nor its timing affect any result. It sets `overrun`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to filter a new sample pair |
| left_in | input | DATA_W | New left sample, signed Q15 |
| right_in | input | DATA_W | New right sample, signed Q15 |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | clog2(TAPS) | Coefficient index to write |
| coef_wdata | input | DATA_W | Coefficient value, signed Q15 |
| left_out | output | DATA_W | Latest left result |
| right_out | output | DATA_W | Latest right result |
| busy | output | 1 | A pair is being processed |
| done | output | 1 | Results ready, held until the next start |
| overrun | output | 1 | Sticky flag: a start arrived while busy |

## Verification
The first pattern uses a two-coefficient kernel (0.5 on the newest sample, 0.25 on the one before) with different left and right sequences. A swapped coefficient order, a shared history or a missed write-before-filter would each change these results, and half-LSB cases expose the rounding direction. The second pattern puts a single coefficient at index 0 and streams 2*TAPS ramp samples. It shows that the oldest sample meets coefficient 0 and that the pointers wrap and resume correctly on every pass. Full-scale inputs with all coefficients at maximum drive both saturation limits. A start injected mid-pass, followed by a later pass, shows that the stray sample never entered either history.

// File: rtl/fir_pkg.sv
package fir_pkg;
    localparam int NUM_CH = 2;
    localparam int CH_W   = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_MAC,
        ST_LAST,
        ST_STORE
    } fir_state_t;
endpackage

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
    parameter int DW   = 16,
    parameter int TAPS = 8,
    parameter int AW   = $clog2(TAPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic signed [DW-1:0] wdata,
    input  logic [AW-1:0]        raddr,
    output logic signed [DW-1:0] rdata
);
    logic signed [DW-1:0] mem [TAPS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++) mem[i] <= '0;
        end else if (we && (32'(waddr) < TAPS)) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fir_delay_bank.sv
module fir_delay_bank
    import fir_pkg::*;
#(
    parameter int DW   = 16,
    parameter int TAPS = 8,
    parameter int AW   = $clog2(TAPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CH_W-1:0]      wr_ch,
    input  logic [AW-1:0]        wr_addr,
    input  logic signed [DW-1:0] wr_data,
    input  logic [CH_W-1:0]      rd_ch,
    input  logic [AW-1:0]        rd_addr,
    output logic signed [DW-1:0] rd_data
);
    logic signed [DW-1:0] ch_rd [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_line
        logic signed [DW-1:0] line [TAPS];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < TAPS; i++) line[i] <= '0;
            end else if (wr_en && (wr_ch == CH_W'(c))) begin
                line[wr_addr] <= wr_data;
            end
        end

        assign ch_rd[c] = line[rd_addr];
    end

    assign rd_data = ch_rd[rd_ch];
endmodule

// File: rtl/fir_mac_unit.sv
module fir_mac_unit #(
    parameter int DW    = 16,
    parameter int ACC_W = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    output logic signed [DW-1:0] result
);
    localparam int PW    = 2 * DW;
    localparam int HEAD  = ACC_W - PW + 1;
    localparam logic signed [DW-1:0] POS_LIM = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] NEG_LIM = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [ACC_W-1:0] HALF =
        {{(ACC_W-DW){1'b0}}, 1'b1, {(DW-1){1'b0}}};

    logic signed [PW-1:0]    prod;
    logic signed [ACC_W-1:0] prod_x;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] rnd;
    logic [HEAD-1:0]         head;
    logic                    ovf;

    // fractional product: signed product shifted by one, sign-extended
    assign prod   = a * b;
    assign prod_x = {{(ACC_W-PW){prod[PW-1]}}, prod} <<< 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   acc_q <= '0;
        else if (clr) acc_q <= '0;
        else if (en)  acc_q <= acc_q + prod_x;
    end

    // round half up, then clamp to the output word
    assign rnd  = acc_q + HALF;
    assign head = rnd[ACC_W-1:PW-1];
    assign ovf  = !((&head) || !(|head));

    always_comb begin
        if (ovf) result = rnd[ACC_W-1] ? NEG_LIM : POS_LIM;
        else     result = rnd[PW-1:DW];
    end
endmodule

// File: rtl/fir_ctrl.sv
module fir_ctrl
    import fir_pkg::*;
#(
    parameter int DW   = 16,
    parameter int TAPS = 8,
    parameter int AW   = $clog2(TAPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic signed [DW-1:0] left_in,
    input  logic signed [DW-1:0] right_in,
    input  logic signed [DW-1:0] mac_result,
    output logic                 wr_en,
    output logic [CH_W-1:0]      wr_ch,
    output logic [AW-1:0]        wr_addr,
    output logic signed [DW-1:0] wr_data,
    output logic [CH_W-1:0]      rd_ch,
    output logic [AW-1:0]        rd_addr,
    output logic [AW-1:0]        coef_raddr,
    output logic                 mac_clr,
    output logic                 mac_en,
    output logic signed [DW-1:0] left_out,
    output logic signed [DW-1:0] right_out,
    output logic                 busy,
    output logic                 done,
    output logic                 overrun
);
    localparam logic [AW:0]   SPAN     = (AW+1)'(TAPS);
    localparam logic [AW-1:0] TAP_PEN  = AW'(TAPS - 2);
    localparam logic [AW-1:0] ONE      = AW'(1);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    fir_state_t state_q, state_d;

    logic [CH_W-1:0]      ch_q;
    logic [AW-1:0]        tap_q;
    logic [AW-1:0]        base_q;
    logic [AW-1:0]        ptr_q [NUM_CH];
    logic signed [DW-1:0] smp_q [NUM_CH];
    logic signed [DW-1:0] out_q [NUM_CH];
    logic                 done_q;
    logic                 ovr_q;
    logic                 accept;

    function automatic logic [AW-1:0] mod_add(input logic [AW-1:0] x,
                                              input logic [AW-1:0] y);
        logic [AW:0] s;
        s = {1'b0, x} + {1'b0, y};
        if (s >= SPAN) s = s - SPAN;
        return s[AW-1:0];
    endfunction

    assign accept = start && (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LOAD;
            ST_LOAD:  state_d = (TAPS > 2) ? ST_MAC : ST_LAST;
            ST_MAC:   if (tap_q == TAP_PEN) state_d = ST_LAST;
            ST_LAST:  state_d = ST_STORE;
            ST_STORE: state_d = (ch_q == LAST_CH) ? ST_IDLE : ST_LOAD;
            default:  state_d = ST_IDLE;
        endcase
    end

    // per-state strobes toward memories and the MAC
    always_comb begin
        wr_en      = (state_q == ST_LOAD);
        wr_ch      = ch_q;
        wr_addr    = ptr_q[ch_q];
        wr_data    = smp_q[ch_q];
        rd_ch      = ch_q;
        rd_addr    = mod_add(base_q, tap_q);
        coef_raddr = tap_q;
        mac_clr    = (state_q == ST_LOAD);
        mac_en     = (state_q == ST_MAC) || (state_q == ST_LAST);
    end

    // registered outputs and datapath bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q   <= '0;
            tap_q  <= '0;
            base_q <= '0;
            done_q <= 1'b0;
            ovr_q  <= 1'b0;
            for (int c = 0; c < NUM_CH; c++) begin
                ptr_q[c] <= '0;
                smp_q[c] <= '0;
                out_q[c] <= '0;
            end
        end else begin
            if (start && !accept) ovr_q <= 1'b1;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        smp_q[0] <= left_in;
                        smp_q[1] <= right_in;
                        ch_q     <= '0;
                        done_q   <= 1'b0;
                    end
                end
                ST_LOAD: begin
                    base_q <= mod_add(ptr_q[ch_q], ONE);
                    tap_q  <= '0;
                end
                ST_MAC: begin
                    tap_q <= tap_q + ONE;
                end
                ST_LAST: begin
                    tap_q <= '0;
                end
                ST_STORE: begin
                    out_q[ch_q] <= mac_result;
                    ptr_q[ch_q] <= base_q;
                    if (ch_q == LAST_CH) done_q <= 1'b1;
                    else                 ch_q   <= ch_q + CH_W'(1);
                end
                default: ;
            endcase
        end
    end

    assign left_out  = out_q[0];
    assign right_out = out_q[1];
    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign overrun   = ovr_q;
endmodule

// File: rtl/stereo_fir_engine.sv
module stereo_fir_engine
    import fir_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TAPS   = 8,
    parameter int ACC_W  = 40
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic signed [DATA_W-1:0]  left_in,
    input  logic signed [DATA_W-1:0]  right_in,
    input  logic                      coef_we,
    input  logic [$clog2(TAPS)-1:0]   coef_addr,
    input  logic signed [DATA_W-1:0]  coef_wdata,
    output logic signed [DATA_W-1:0]  left_out,
    output logic signed [DATA_W-1:0]  right_out,
    output logic                      busy,
    output logic                      done,
    output logic                      overrun
);
    localparam int AW = $clog2(TAPS);

    logic                     wr_en;
    logic [CH_W-1:0]          wr_ch;
    logic [AW-1:0]            wr_addr;
    logic signed [DATA_W-1:0] wr_data;
    logic [CH_W-1:0]          rd_ch;
    logic [AW-1:0]            rd_addr;
    logic [AW-1:0]            coef_raddr;
    logic signed [DATA_W-1:0] hist_q;
    logic signed [DATA_W-1:0] coef_q;
    logic                     mac_clr;
    logic                     mac_en;
    logic signed [DATA_W-1:0] mac_result;

    fir_ctrl #(.DW(DATA_W), .TAPS(TAPS), .AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .left_in    (left_in),
        .right_in   (right_in),
        .mac_result (mac_result),
        .wr_en      (wr_en),
        .wr_ch      (wr_ch),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_ch      (rd_ch),
        .rd_addr    (rd_addr),
        .coef_raddr (coef_raddr),
        .mac_clr    (mac_clr),
        .mac_en     (mac_en),
        .left_out   (left_out),
        .right_out  (right_out),
        .busy       (busy),
        .done       (done),
        .overrun    (overrun)
    );

    fir_coef_bank #(.DW(DATA_W), .TAPS(TAPS), .AW(AW)) u_coef (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (coef_we),
        .waddr (coef_addr),
        .wdata (coef_wdata),
        .raddr (coef_raddr),
        .rdata (coef_q)
    );

    fir_delay_bank #(.DW(DATA_W), .TAPS(TAPS), .AW(AW)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_ch   (rd_ch),
        .rd_addr (rd_addr),
        .rd_data (hist_q)
    );

    fir_mac_unit #(.DW(DATA_W), .ACC_W(ACC_W)) u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (mac_clr),
        .en     (mac_en),
        .a      (hist_q),
        .b      (coef_q),
        .result (mac_result)
    );
endmodule

// File: rtl/fir_engine_checker.sv
module fir_engine_checker #(
    parameter int DW   = 16,
    parameter int TAPS = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          overrun,
    input logic [DW-1:0] left_out,
    input logic [DW-1:0] right_out
);
    localparam int LAT = 2 * TAPS + 4;

    logic [31:0] lat_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              lat_cnt <= '0;
        else if (start && !busy) lat_cnt <= '0;
        else if (busy)           lat_cnt <= lat_cnt + 32'd1;
    end

    a_r7_busy_excludes_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    a_r7_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (lat_cnt == 32'(LAT)));

    a_r3_start_enters_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(left_out) && $stable(right_out)));

    a_r9_busy_start_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> overrun);

    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
endmodule

bind stereo_fir_engine fir_engine_checker #(.DW(DATA_W), .TAPS(TAPS)) u_fir_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .overrun   (overrun),
    .left_out  (left_out),
    .right_out (right_out)
);

// File: tb/stereo_fir_engine_bench.sv
module stereo_fir_engine_bench;
    localparam int TAPS = 8;
    localparam int AW   = $clog2(TAPS);
    localparam int LAT  = 2 * TAPS + 4;
    localparam int NVEC = 6;

    // {left_in, right_in, expected left_out, expected right_out}
    // kernel: c[TAPS-1] = 0.5, c[TAPS-2] = 0.25, others zero
    localparam logic [63:0] VEC [NVEC] = '{
        {16'sd1000,  -16'sd800,  16'sd500,   -16'sd400},
        {16'sd2000,  16'sd1200,  16'sd1250,  16'sd400},
        {-16'sd4000, 16'sd0,     -16'sd1500, 16'sd300},
        {16'sd0,     16'sd3200,  -16'sd1000, 16'sd1600},
        {16'sd400,   -16'sd400,  16'sd200,   16'sd600},
        {16'sd3,     -16'sd3,    16'sd102,   -16'sd101}
    };

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start = 1'b0;
    logic signed [15:0]     left_in = '0;
    logic signed [15:0]     right_in = '0;
    logic                   coef_we = 1'b0;
    logic [AW-1:0]          coef_addr = '0;
    logic signed [15:0]     coef_wdata = '0;
    logic signed [15:0]     left_out;
    logic signed [15:0]     right_out;
    logic                   busy;
    logic                   done;
    logic                   overrun;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    stereo_fir_engine #(.DATA_W(16), .TAPS(TAPS), .ACC_W(40)) u_stereo_fir_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .left_in    (left_in),
        .right_in   (right_in),
        .coef_we    (coef_we),
        .coef_addr  (coef_addr),
        .coef_wdata (coef_wdata),
        .left_out   (left_out),
        .right_out  (right_out),
        .busy       (busy),
        .done       (done),
        .overrun    (overrun)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start = 1'b0;
        coef_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_coef(input int idx, input logic signed [15:0] val);
        coef_we = 1'b1;
        coef_addr = AW'(idx);
        coef_wdata = val;
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    // accept one pair; returns edges from accepting edge until done seen
    task automatic run_pass(input logic signed [15:0] l, input logic signed [15:0] r,
                            input bool_stray, output int lat);
        start = 1'b1;
        left_in = l;
        right_in = r;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        check("R8", "done cleared by start", int'(done), 0);
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
            if (bool_stray && lat == 3) begin
                start = 1'b1;
                left_in = 16'sd9999;
                right_in = 16'sd9999;
            end else begin
                start = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lat;
        int xl [2*TAPS];
        int xr [2*TAPS];

        // reset state
        do_reset();
        check("R1", "left_out", int'(left_out), 0);
        check("R1", "right_out", int'(right_out), 0);
        check("R1", "done", int'(done), 0);
        check("R1", "busy", int'(busy), 0);
        check("R1", "overrun", int'(overrun), 0);
        run_pass(16'sd12345, -16'sd12345, 1'b0, lat);
        check("R1", "zero coef left", int'(left_out), 0);
        check("R1", "zero coef right", int'(right_out), 0);

        // vector table: two-tap kernel, independent channels
        do_reset();
        write_coef(TAPS-1, 16'sh4000);
        write_coef(TAPS-2, 16'sh2000);
        for (int i = 0; i < NVEC; i++) begin
            run_pass(VEC[i][63:48], VEC[i][47:32], 1'b0, lat);
            check("R4", $sformatf("vec%0d left", i), int'($signed(left_out)),
                  int'($signed(VEC[i][31:16])));
            check("R3", $sformatf("vec%0d right", i), int'($signed(right_out)),
                  int'($signed(VEC[i][15:0])));
            check("R7", $sformatf("vec%0d latency", i), lat, LAT);
        end
        check("R5", "round half up positive", int'(left_out), 102);
        check("R5", "round half up negative", int'(right_out), -101);

        // hold after done
        repeat (5) @(negedge clk);
        check("R8", "done held", int'(done), 1);
        check("R8", "left held", int'(left_out), 102);
        check("R8", "right held", int'(right_out), -101);
        check("R9", "no overrun yet", int'(overrun), 0);

        // stray start during busy is ignored and flagged
        run_pass(16'sd40, -16'sd40, 1'b1, lat);
        check("R9", "overrun set", int'(overrun), 1);
        check("R9", "stray ignored left", int'(left_out), 21);
        check("R9", "stray ignored right", int'(right_out), -21);
        check("R7", "latency with stray", lat, LAT);
        run_pass(16'sd0, 16'sd0, 1'b0, lat);
        check("R9", "history untouched left", int'(left_out), 10);
        check("R9", "history untouched right", int'(right_out), -10);
        check("R9", "overrun sticky", int'(overrun), 1);

        // coefficient 0 meets the oldest sample; pointer wrap over 2*TAPS passes
        do_reset();
        check("R1", "overrun cleared by reset", int'(overrun), 0);
        write_coef(0, 16'sh4000);
        for (int n = 0; n < 2*TAPS; n++) begin
            xl[n] = 200 * (n + 1);
            xr[n] = -400 * (n + 1);
            run_pass(16'(xl[n]), 16'(xr[n]), 1'b0, lat);
            check("R4", $sformatf("oldest tap left n=%0d", n), int'(left_out),
                  (n >= TAPS-1) ? xl[n-TAPS+1] / 2 : 0);
            check("R3", $sformatf("oldest tap right n=%0d", n), int'(right_out),
                  (n >= TAPS-1) ? xr[n-TAPS+1] / 2 : 0);
        end

        // saturation at both limits
        do_reset();
        for (int k = 0; k < TAPS; k++) write_coef(k, 16'sh7FFF);
        run_pass(16'sh7FFF, 16'sh8000, 1'b0, lat);
        check("R5", "full scale one sample left", int'(left_out), 32766);
        check("R5", "full scale one sample right", int'(right_out), -32767);
        run_pass(16'sh7FFF, 16'sh8000, 1'b0, lat);
        check("R6", "positive limit", int'(left_out), 32767);
        check("R6", "negative limit", int'(right_out), -32768);
        check("R2", "all coefficients written", lat, LAT);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule